// File: doc/BRIEF.md
# Coarse-Fine Folding Converter Output Encoder

This block turns the two comparator banks of a folding analog-to-digital converter into one 9-bit binary sample. A 9-comparator coarse bank reports, as a thermometer, which fold the input lies in. A 63-comparator fine bank reports the position inside that fold as a thermometer whose direction flips on every other fold. Each fold spans 63 steps rather than 64, so a plain concatenation of coarse and fine bits would skip one code per fold.

No switching matrix is used to fix this. The fold index drives an offset table whose entry is added to the fine residue in a 7-bit adder. The low six sum bits form the fine field. The adder's top bit then picks the coarse field from one of two further tables: the fold index itself, or the fold index minus one when the subtraction borrowed. The fine and coarse paths resolve independently and meet only at the adder. The path is fully pipelined, takes a new sample every clock, and has a fixed two-cycle latency.

Top module: `fold_encoder`

## Requirements
- R1: `out_valid` equals the `in_valid` that was presented two rising clock edges earlier, and a new sample is accepted on every edge.
- R2: While `rst` is high at a rising edge, the next edge leaves `out_valid` at 0 and `out_code` at 0.
- R3: The fold index is the number of consecutive ones in `coarse_therm` counted upward from bit 0, capped at 8. A one that lies above the first zero is ignored, and all nine ones give index 8.
- R4: The fine count is the number of ones anywhere in `fine_therm`, capped at 62. On even fold indices the residue equals the count; on odd fold indices it equals 62 minus the count.
- R5: The residue plus an offset of (64 minus the fold index) forms a 7-bit sum. Its bits 5:0 appear as `out_code[5:0]`, so fold index f with residue r yields low bits (r - f) mod 64.
- R6: When bit 6 of that sum is 1 (r >= f), `out_code[8:6]` equals the fold index. When it is 0 (r < f), `out_code[8:6]` equals the fold index minus one. The result is `out_code = 63*f + r`.
- R7: Sweeping an input level x from 0 to 511 (fold x/63, residue x mod 63) produces `out_code = x`, which is strictly increasing.
- R8: Fold index 8 with a residue of 8 or more gives `out_code = 511`.
- R9: When the sample presented two edges earlier had `in_valid` low, `out_code` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Comparator outputs on this edge form a sample |
| coarse_therm | input | 9 | Coarse comparator outputs, bit 0 lowest threshold |
| fine_therm | input | 63 | Fine comparator outputs |
| out_valid | output | 1 | `out_code` carries a new sample |
| out_code | output | 9 | Binary output sample |

## Verification
The interaction that matters most is between the fold mirroring and the adder's borrow-driven table choice. Both act in the same cycle when an odd fold index meets a residue smaller than the index. In that case the mirrored count decides whether the adder borrows, and the borrow decides which coarse table is used. These cases are provoked by a full-scale ramp that crosses every fold boundary, by directed odd-fold samples just either side of the borrow point, and by random comparator patterns that include bubbles. Every output is compared against the arithmetic form 63*f + r, computed in the bench from the requirement definitions, with the saturation rule applied.

// File: rtl/fold_encoder_pkg.sv
package fold_encoder_pkg;

    localparam int CRS_CMP   = 9;
    localparam int FINE_CMP  = 63;
    localparam int FOLD_MAX  = 8;
    localparam int IDX_W     = $clog2(FOLD_MAX + 1);
    localparam int CNT_W     = $clog2(FINE_CMP);
    localparam int FIELD_W   = 6;
    localparam int SUM_W     = FIELD_W + 1;
    localparam int CRS_W     = 3;
    localparam int CODE_W    = CRS_W + FIELD_W;

    typedef struct packed {
        logic                valid;
        logic [CRS_CMP-1:0]  crs;
        logic [FINE_CMP-1:0] fine;
    } raw_sample_t;

    typedef struct packed {
        logic [CRS_W-1:0] crs;
        logic             sat;
    } crs_entry_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } enc_out_t;

    // Offset added to the fine residue: 64 minus the fold index.
    function automatic logic [SUM_W-1:0] offset_rom(input logic [IDX_W-1:0] idx);
        logic [SUM_W-1:0] v;
        case (idx)
            4'd0:    v = 7'd64;
            4'd1:    v = 7'd63;
            4'd2:    v = 7'd62;
            4'd3:    v = 7'd61;
            4'd4:    v = 7'd60;
            4'd5:    v = 7'd59;
            4'd6:    v = 7'd58;
            4'd7:    v = 7'd57;
            4'd8:    v = 7'd56;
            default: v = 7'd56;
        endcase
        return v;
    endfunction

    // Coarse field when the adder borrowed (top sum bit clear).
    function automatic crs_entry_t borrow_rom(input logic [IDX_W-1:0] idx);
        crs_entry_t e;
        e.sat = 1'b0;
        case (idx)
            4'd0:    e.crs = 3'd0;
            4'd1:    e.crs = 3'd0;
            4'd2:    e.crs = 3'd1;
            4'd3:    e.crs = 3'd2;
            4'd4:    e.crs = 3'd3;
            4'd5:    e.crs = 3'd4;
            4'd6:    e.crs = 3'd5;
            4'd7:    e.crs = 3'd6;
            4'd8:    e.crs = 3'd7;
            default: begin e.crs = 3'd7; e.sat = 1'b1; end
        endcase
        return e;
    endfunction

    // Coarse field when the adder did not borrow (top sum bit set).
    function automatic crs_entry_t direct_rom(input logic [IDX_W-1:0] idx);
        crs_entry_t e;
        e.sat = 1'b0;
        case (idx)
            4'd0:    e.crs = 3'd0;
            4'd1:    e.crs = 3'd1;
            4'd2:    e.crs = 3'd2;
            4'd3:    e.crs = 3'd3;
            4'd4:    e.crs = 3'd4;
            4'd5:    e.crs = 3'd5;
            4'd6:    e.crs = 3'd6;
            4'd7:    e.crs = 3'd7;
            default: begin e.crs = 3'd7; e.sat = 1'b1; end
        endcase
        return e;
    endfunction

endpackage

// File: rtl/fold_coarse_decode.sv
module fold_coarse_decode
    import fold_encoder_pkg::*;
#(
    parameter int N_CMP   = CRS_CMP,
    parameter int MAX_IDX = FOLD_MAX,
    parameter int W       = IDX_W
) (
    input  logic [N_CMP-1:0] therm,
    output logic [W-1:0]     idx,
    output logic             odd
);
    int   run_len;
    logic run;

    always_comb begin
        run_len = 0;
        run     = 1'b1;
        for (int i = 0; i < N_CMP; i++) begin
            if (run && therm[i]) begin
                run_len = run_len + 1;
            end else begin
                run = 1'b0;
            end
        end
        if (run_len > MAX_IDX) begin
            run_len = MAX_IDX;
        end
        idx = W'(run_len);
        odd = idx[0];
    end
endmodule

// File: rtl/fold_fine_decode.sv
module fold_fine_decode
    import fold_encoder_pkg::*;
#(
    parameter int N_CMP = FINE_CMP,
    parameter int W     = CNT_W
) (
    input  logic [N_CMP-1:0] therm,
    input  logic             odd_fold,
    output logic [W-1:0]     residue
);
    localparam int TOP = N_CMP - 1;

    int         ones;
    logic [W-1:0] cnt;

    always_comb begin
        ones = 0;
        for (int i = 0; i < N_CMP; i++) begin
            ones = ones + int'(therm[i]);
        end
        if (ones > TOP) begin
            ones = TOP;
        end
        cnt     = W'(ones);
        residue = odd_fold ? (W'(TOP) - cnt) : cnt;
    end
endmodule

// File: rtl/fold_code_merge.sv
module fold_code_merge
    import fold_encoder_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [CNT_W-1:0]  residue,
    output logic [CODE_W-1:0] code
);
    logic [SUM_W-1:0] sum;
    crs_entry_t       sel;

    always_comb begin
        sum = SUM_W'(residue) + offset_rom(idx);
        sel = sum[SUM_W-1] ? direct_rom(idx) : borrow_rom(idx);
        if (sel.sat) begin
            code = '1;
        end else begin
            code = {sel.crs, sum[FIELD_W-1:0]};
        end
    end
endmodule

// File: rtl/fold_encoder.sv
module fold_encoder
    import fold_encoder_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [CRS_CMP-1:0]  coarse_therm,
    input  logic [FINE_CMP-1:0] fine_therm,
    output logic                out_valid,
    output logic [CODE_W-1:0]   out_code
);
    raw_sample_t       s1;
    enc_out_t          s2;
    logic [IDX_W-1:0]  fold_idx;
    logic              fold_odd;
    logic [CNT_W-1:0]  fold_res;
    logic [CODE_W-1:0] merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            s1.crs   <= coarse_therm;
            s1.fine  <= fine_therm;
        end
    end

    fold_coarse_decode u_crs (
        .therm (s1.crs),
        .idx   (fold_idx),
        .odd   (fold_odd)
    );

    fold_fine_decode u_fine (
        .therm    (s1.fine),
        .odd_fold (fold_odd),
        .residue  (fold_res)
    );

    fold_code_merge u_merge (
        .idx     (fold_idx),
        .residue (fold_res),
        .code    (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.valid <= s1.valid;
            if (s1.valid) begin
                s2.code <= merged;
            end
        end
    end

    assign out_valid = s2.valid;
    assign out_code  = s2.code;
endmodule

// File: rtl/fold_encoder_chk.sv
module fold_encoder_chk
    import fold_encoder_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [CRS_CMP-1:0]  coarse_therm,
    input logic [FINE_CMP-1:0] fine_therm,
    input logic                out_valid,
    input logic [CODE_W-1:0]   out_code
);
    logic [1:0] age;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end
    assign armed = (age >= 2'd2);

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(in_valid, 2)));

    a_r2_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_code == '0));

    a_r3_fold_zero_range: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && !$past(coarse_therm[0], 2)) |-> (out_code < 10'd63));

    a_r4_odd_mirror: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && $past(coarse_therm, 2) == 9'h001 && $past(fine_therm, 2) == '0)
        |-> (out_code == 9'd125));

    a_r9_hold_code: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(in_valid, 2)) |-> $stable(out_code));
endmodule

bind fold_encoder fold_encoder_chk u_chk (.*);

// File: tb/sim_fold_encoder.sv
module sim_fold_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [8:0]  coarse_therm = '0;
    logic [62:0] fine_therm = '0;
    logic        out_valid;
    logic [8:0]  out_code;

    int checks = 0;
    int failures = 0;

    logic       pv_a = 1'b0, pv_b = 1'b0;
    logic [8:0] pc_a = '0, pc_b = '0;
    string      pr_a = "", pr_b = "";
    logic [8:0] held = '0;

    always #10 clk = ~clk;

    fold_encoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .coarse_therm(coarse_therm), .fine_therm(fine_therm),
        .out_valid(out_valid), .out_code(out_code)
    );

    function automatic logic [8:0] model(input logic [8:0] cv, input logic [62:0] fv);
        int idx = 0;
        bit run = 1'b1;
        int c;
        int r;
        for (int i = 0; i < 9; i++) begin
            if (run && cv[i]) idx++;
            else run = 1'b0;
        end
        if (idx > 8) idx = 8;
        c = $countones(fv);
        if (c > 62) c = 62;
        r = (idx % 2 == 1) ? 62 - c : c;
        if (idx == 8 && r >= 8) return 9'd511;
        return 9'(63 * idx + r);
    endfunction

    function automatic logic [8:0] crs_vec(input int f);
        return 9'((1 << f) - 1);
    endfunction

    function automatic logic [62:0] fine_vec(input int c);
        logic [62:0] v = '0;
        for (int i = 0; i < 63; i++) if (i < c) v[i] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [8:0] cv, input logic [62:0] fv, input string req);
        check(out_valid == pv_b, "R1", int'(out_valid), int'(pv_b));
        if (pv_b) begin
            check(out_code == pc_b, pr_b, int'(out_code), int'(pc_b));
            held = pc_b;
        end else begin
            check(out_code == held, "R9", int'(out_code), int'(held));
        end
        pv_b = pv_a; pc_b = pc_a; pr_b = pr_a;
        pv_a = v; pc_a = model(cv, fv); pr_a = req;
        in_valid = v; coarse_therm = cv; fine_therm = fv;
        @(negedge clk);
    endtask

    task automatic level(input int x, input string req);
        int f = x / 63;
        int r = x % 63;
        int c = (f % 2 == 1) ? 62 - r : r;
        cycle(1'b1, crs_vec(f), fine_vec(c), req);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        in_valid = 1'b1;
        coarse_therm = 9'h1FF;
        fine_therm = '1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        check(out_code == 9'd0, "R2", int'(out_code), 0);
        rst = 1'b0;
        in_valid = 1'b0;

        // R7: full-scale ramp, back to back
        for (int x = 0; x < 512; x++) level(x, "R7");
        // R3: bubble above first zero, and all ones
        cycle(1'b1, 9'b000000101, fine_vec(0), "R3");
        cycle(1'b1, 9'h1FF, fine_vec(3), "R3");
        cycle(1'b1, 9'b100000000, fine_vec(10), "R3");
        // R4: saturated count, scattered ones, odd mirror
        cycle(1'b1, crs_vec(2), '1, "R4");
        cycle(1'b1, crs_vec(1), 63'h5555_0000_0000_00F0, "R4");
        cycle(1'b1, crs_vec(1), fine_vec(0), "R4");
        // R5/R6: odd fold 3, residue below (borrow) and above (no borrow) the index
        level(63 * 3 + 2, "R6");
        level(63 * 3 + 5, "R6");
        level(63 * 3 + 3, "R5");
        level(63 * 8 + 7, "R5");
        // R8: top fold with large residue
        cycle(1'b1, crs_vec(8), fine_vec(20), "R8");
        cycle(1'b1, 9'h1FF, fine_vec(62), "R8");
        // R9: invalid samples with junk must leave the code alone
        cycle(1'b0, 9'h0AA, '1, "R9");
        cycle(1'b0, 9'h000, 63'h1234, "R9");
        cycle(1'b0, 9'h1FF, '0, "R9");
        level(100, "R9");
        // random mix, including bubbles
        for (int k = 0; k < 3000; k++) begin
            logic v = ($urandom % 4) != 0;
            logic [8:0] cv;
            logic [62:0] fv;
            if ($urandom % 4 == 0) begin
                cv = 9'($urandom);
                fv = {31'($urandom), $urandom};
            end else begin
                cv = crs_vec(int'($urandom % 9));
                fv = fine_vec(int'($urandom % 64));
            end
            cycle(v, cv, fv, "R7");
        end
        // drain
        cycle(1'b0, '0, '0, "R9");
        cycle(1'b0, '0, '0, "R9");
        cycle(1'b0, '0, '0, "R9");
        finish_run();
    end
endmodule